// File: doc/BRIEF.md
# Parallel 8080-Style Panel Write Interface

This block feeds a command-mode display panel over a parallel bus made of an active-low chip select, an active-low write strobe and a data bus. Each pixel word gets its own chip-select cycle, split into four timed phases. The length of each phase comes from a 4-bit field of a configuration word. A frame transfer can start in three ways: a software command, a rising edge on the panel's tearing-effect line, or an optional automatic refresh timer. While a frame is being sent, any further start request is dropped, because a second start would disturb the panel.

Pixel words arrive on a valid/ready stream, and a last flag marks the final word of the frame. When the last word has been written, the block returns to idle and sets a sticky done flag. That flag drives the interrupt output when the interrupt is enabled. The busy state always clears at the end of the frame, so the block cannot stay locked even when the interrupt is disabled.

Settings reach the block through a small write-only register port with four word addresses:
- Address 0: interface configuration.
- Address 1: trigger control.
- Address 2: automatic refresh period.
- Address 3: interrupt control.

Top module: `panel_wr8080`

## Requirements
- R1: After reset, the outputs are: cs_n_o=1, wr_n_o=1, busy_o=0, done_o=0, irq_o=0 and pix_ready_o=0.
- R2: The configuration word at address 0 holds these fields:
  - bits [19:16]: chip-select setup CS.
  - bits [15:12]: write setup WS.
  - bits [11:8]: write-active width WA.
  - bits [7:4]: write hold WH.
  - bit 0: interface enable.

  A field value N lasts N+1 clock cycles. For each word, chip select is low with the write strobe high for CS+WS+2 cycles, then the write strobe is low for WA+1 cycles, then the write strobe is high with chip select still low for WH+1 cycles.
- R3: Chip select returns high between any two words. data_o carries the accepted words in stream order, and it holds steady while the write strobe is low.
- R4: A write to address 1 with bit 0 (trigger mode) and bit 1 (software command) both set starts a frame. Bit 1 is not stored. No frame starts when bit 0 is clear, or when the interface enable bit is clear.
- R5: A rising edge on te_i starts a frame only when the stored trigger control has bit 0, bit 3 (hardware trigger enable) and bit 4 (hardware trigger unmask) all set.
- R6: When bit 31 of trigger control is set, every rising edge on te_i may start a frame. When bit 31 is clear, a trigger-control write with bit 3 set arms exactly one tearing-effect start.
- R7: Software, tearing-effect and automatic start requests that arrive while a frame is busy are ignored. The frame in progress writes only its own words, and no extra frame follows it.
- R8: A frame ends after the write of the word that carried pix_last_i. busy_o then falls, whether or not the interrupt is enabled.
- R9: done_o is set at frame end and stays set. Writing address 3 with bit 0 set clears it. If a set and a clear fall in the same cycle, the set wins. Bit 1 of address 3 is the interrupt enable, and irq_o is done_o gated by that enable.
- R10: A non-zero value P in bits [15:0] of address 2 starts a new frame after P idle cycles. A value of zero disables automatic refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| te_i | input | 1 | Tearing-effect line from the panel |
| pix_valid_i | input | 1 | Pixel word valid |
| pix_data_i | input | DW | Pixel word |
| pix_last_i | input | 1 | Last word of the frame |
| pix_ready_o | output | 1 | Pixel word accepted this cycle when valid |
| cs_n_o | output | 1 | Panel chip select, active low |
| wr_n_o | output | 1 | Panel write strobe, active low |
| data_o | output | DW | Panel data bus |
| busy_o | output | 1 | Frame transfer in progress |
| done_o | output | 1 | Sticky frame-done flag |
| irq_o | output | 1 | Frame-done interrupt |

## Verification
Two events can land in the same cycle: the frame-end edge that sets the done flag, and a register write that clears it. The bench lengthens the hold phase to sixteen cycles and counts cycles from the rising edge of the write strobe. This lets it place the clear write exactly on the clock edge where the last hold cycle ends. It then expects done_o to read 1, and a separate clear write afterwards must bring it back to 0.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CSS, ST_WRS, ST_ACT, ST_HOLD
  } wr_state_e;

  // configuration word field positions
  localparam int unsigned CSS_POS   = 16;
  localparam int unsigned WRS_POS   = 12;
  localparam int unsigned ACT_POS   = 8;
  localparam int unsigned HOLD_POS  = 4;
  localparam int unsigned IF_EN_BIT = 0;
  localparam int unsigned NPH       = 4;

  // trigger control bits
  localparam int unsigned TRG_MODE   = 0;
  localparam int unsigned TRG_SW     = 1;
  localparam int unsigned TRG_HW     = 3;
  localparam int unsigned TRG_UNMASK = 4;
  localparam int unsigned TRG_PER_TE = 31;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_TRIG = 2'd1;
  localparam logic [1:0] A_AFR  = 2'd2;
  localparam logic [1:0] A_IRQ  = 2'd3;
endpackage

// File: rtl/pwr_trigger.sv
module pwr_trigger #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_we_i,
  input  logic          mode_i,
  input  logic          cmd_i,
  input  logic          hw_en_i,
  input  logic          unmask_i,
  input  logic          per_te_i,
  input  logic          afr_we_i,
  input  logic [AW-1:0] afr_i,
  input  logic          te_i,
  input  logic          if_en_i,
  input  logic          busy_i,
  output logic          start_o
);
  logic mode_q, hw_en_q, unmask_q, per_te_q, armed_q, te_q;
  logic [AW-1:0] afr_q, idle_cnt_q;
  logic can_go, te_rise, sw_fire, hw_fire, auto_fire;

  assign can_go    = if_en_i & ~busy_i;
  assign te_rise   = te_i & ~te_q;
  assign sw_fire   = trig_we_i & mode_i & cmd_i;
  assign hw_fire   = mode_q & hw_en_q & unmask_q & te_rise & (per_te_q | armed_q);
  assign auto_fire = (afr_q != '0) && (idle_cnt_q >= afr_q - 1'b1);
  assign start_o   = can_go & (sw_fire | hw_fire | auto_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      hw_en_q    <= 1'b0;
      unmask_q   <= 1'b0;
      per_te_q   <= 1'b0;
      armed_q    <= 1'b0;
      te_q       <= 1'b0;
      afr_q      <= '0;
      idle_cnt_q <= '0;
    end else begin
      te_q <= te_i;
      if (trig_we_i) begin
        mode_q   <= mode_i;
        hw_en_q  <= hw_en_i;
        unmask_q <= unmask_i;
        per_te_q <= per_te_i;
        armed_q  <= hw_en_i;
      end else if (start_o && hw_fire) begin
        armed_q  <= 1'b0;
      end
      if (afr_we_i) afr_q <= afr_i;
      if (!can_go || afr_q == '0 || start_o) idle_cnt_q <= '0;
      else                                   idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end

  // R7: a start is only issued to an idle sequencer
  a_r7_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_i);
endmodule

// File: rtl/pwr_strobe_fsm.sv
module pwr_strobe_fsm
  import pwr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NPH-1:0][TW-1:0] ph_len_i,
  input  logic                   pix_valid_i,
  input  logic [DW-1:0]          pix_data_i,
  input  logic                   pix_last_i,
  output logic                   pix_ready_o,
  output logic                   cs_n_o,
  output logic                   wr_n_o,
  output logic [DW-1:0]          data_o,
  output logic                   busy_o,
  output logic                   frame_end_o
);
  wr_state_e st_q, st_d;
  logic [TW-1:0] cnt_q, ld;
  logic [DW-1:0] data_q;
  logic          last_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d        = st_q;
    ld          = ph_len_i[0];
    frame_end_o = 1'b0;
    case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_FETCH;
      ST_FETCH: if (pix_valid_i) st_d = ST_CSS;
      ST_CSS:   if (cnt_zero) begin st_d = ST_WRS; ld = ph_len_i[1]; end
      ST_WRS:   if (cnt_zero) begin st_d = ST_ACT; ld = ph_len_i[2]; end
      ST_ACT:   if (cnt_zero) begin st_d = ST_HOLD; ld = ph_len_i[3]; end
      ST_HOLD:
        if (cnt_zero) begin
          if (last_q) begin
            st_d        = ST_IDLE;
            frame_end_o = 1'b1;
          end else begin
            st_d = ST_FETCH;
          end
        end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) cnt_q <= ld;
      else if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
      if (st_q == ST_FETCH && pix_valid_i) begin
        data_q <= pix_data_i;
        last_q <= pix_last_i;
      end
    end
  end

  assign pix_ready_o = (st_q == ST_FETCH);
  assign cs_n_o      = !(st_q inside {ST_CSS, ST_WRS, ST_ACT, ST_HOLD});
  assign wr_n_o      = (st_q != ST_ACT);
  assign busy_o      = (st_q != ST_IDLE);
  assign data_o      = data_q;

  // R2: strobe falls only after chip select has been low
  a_r2_setup_before_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_n_o) |-> $past(!cs_n_o));
  // R2: chip select never rises straight out of the active phase
  a_r2_hold_before_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> $past(wr_n_o));
  // R3: data steady during strobe
  a_r3_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o && $past(!wr_n_o)) |-> $stable(data_o));
  // R8: the end of a frame releases busy
  a_r8_end_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !busy_o);
endmodule

// File: rtl/panel_wr8080.sv
module panel_wr8080
  import pwr_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 4,
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          te_i,
  input  logic          pix_valid_i,
  input  logic [DW-1:0] pix_data_i,
  input  logic          pix_last_i,
  output logic          pix_ready_o,
  output logic          cs_n_o,
  output logic          wr_n_o,
  output logic [DW-1:0] data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o
);
  localparam int unsigned PH_POS [NPH] = '{CSS_POS, WRS_POS, ACT_POS, HOLD_POS};

  logic [NPH-1:0][TW-1:0] tim_d, tim_q;
  logic if_en_q, ie_q, done_q;
  logic wr_cfg, wr_trig, wr_afr, wr_irq, done_clr;
  logic start, frame_end, busy;
  logic unused_wdata;

  assign wr_cfg   = reg_we_i && (reg_addr_i == A_CFG);
  assign wr_trig  = reg_we_i && (reg_addr_i == A_TRIG);
  assign wr_afr   = reg_we_i && (reg_addr_i == A_AFR);
  assign wr_irq   = reg_we_i && (reg_addr_i == A_IRQ);
  assign done_clr = wr_irq && reg_wdata_i[0];
  assign unused_wdata = ^reg_wdata_i[30:20];

  for (genvar g = 0; g < NPH; g++) begin : g_fld
    assign tim_d[g] = reg_wdata_i[PH_POS[g] +: TW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q   <= '0;
      if_en_q <= 1'b0;
      ie_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        tim_q   <= tim_d;
        if_en_q <= reg_wdata_i[IF_EN_BIT];
      end
      if (wr_irq) ie_q <= reg_wdata_i[1];
      done_q <= frame_end | (done_q & ~done_clr);  // set wins
    end
  end

  pwr_trigger #(.AW(AW)) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_we_i (wr_trig),
    .mode_i    (reg_wdata_i[TRG_MODE]),
    .cmd_i     (reg_wdata_i[TRG_SW]),
    .hw_en_i   (reg_wdata_i[TRG_HW]),
    .unmask_i  (reg_wdata_i[TRG_UNMASK]),
    .per_te_i  (reg_wdata_i[TRG_PER_TE]),
    .afr_we_i  (wr_afr),
    .afr_i     (reg_wdata_i[AW-1:0]),
    .te_i      (te_i),
    .if_en_i   (if_en_q),
    .busy_i    (busy),
    .start_o   (start)
  );

  pwr_strobe_fsm #(.DW(DW), .TW(TW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .ph_len_i    (tim_q),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .pix_last_i  (pix_last_i),
    .pix_ready_o (pix_ready_o),
    .cs_n_o      (cs_n_o),
    .wr_n_o      (wr_n_o),
    .data_o      (data_o),
    .busy_o      (busy),
    .frame_end_o (frame_end)
  );

  assign busy_o = busy;
  assign done_o = done_q;
  assign irq_o  = done_q & ie_q;

  // R9: frame end sets done, even against a same-cycle clear
  a_r9_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> done_o);
  // R9: done only drops through an explicit clear
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_clr) |=> done_o);
endmodule

// File: tb/tb_panel_wr8080.sv
`timescale 1ns/1ps
module tb_panel_wr8080;
  localparam int DW = 16;
  localparam logic [15:0] TV [4] = '{16'h0000, 16'h1234, 16'hF072, 16'h3F0F};

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic te = 0;
  logic src_valid = 0; int src_n = 1;
  logic [31:0] src_idx = 0, src_total = 0;
  logic pix_last, pix_ready, cs_n, wr_n, busy, done, irq;
  logic [DW-1:0] pix_data, data;

  assign pix_last = (src_idx == src_n - 1);
  assign pix_data = 16'hC000 ^ src_total[15:0];

  panel_wr8080 #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .te_i(te), .pix_valid_i(src_valid),
    .pix_data_i(pix_data), .pix_last_i(pix_last), .pix_ready_o(pix_ready),
    .cs_n_o(cs_n), .wr_n_o(wr_n), .data_o(data), .busy_o(busy),
    .done_o(done), .irq_o(irq));

  always @(posedge clk) if (src_valid && pix_ready) begin
    src_total <= src_total + 1;
    src_idx   <= pix_last ? 0 : src_idx + 1;
  end

  int checks = 0, fails = 0, cyc = 0;
  bit wd_hit = 0;

  // bus monitor
  logic prev_cs = 1, prev_wr = 1, seen_wr = 0;
  int pre = 0, act = 0, post = 0, m_pre = 0, m_act = 0, m_post = 0;
  int words = 0, data_err = 0, idle_run = 0, last_idle = 0;
  logic [31:0] mon_total = 0;
  logic [DW-1:0] wr_data = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        if (!wr_n) begin
          act++; seen_wr = 1;
          if (prev_wr) begin
            wr_data = data;
            if (data !== (16'hC000 ^ mon_total[15:0])) data_err++;
            mon_total++;
          end else if (data !== wr_data) data_err++;
        end else if (seen_wr) post++;
        else pre++;
      end else if (!prev_cs) begin
        m_pre = pre; m_act = act; m_post = post; words++;
        pre = 0; act = 0; post = 0; seen_wr = 0;
      end
      if (!busy) idle_run++;
      else if (idle_run > 0) begin last_idle = idle_run; idle_run = 0; end
      prev_cs = cs_n; prev_wr = wr_n;
    end
  end

  task automatic chk(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic te_pulse();
    @(negedge clk); te = 1;
    repeat (3) @(negedge clk);
    te = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1; checks++; fails++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n", cs_n, 1);
    chk("R1", "wr_n", wr_n, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "ready", pix_ready, 0);
    rst_n = 1;
    src_valid = 1; src_n = 1;

    // R2 phase timing table
    for (int i = 0; i < 4; i++) begin
      reg_wr(0, {12'h0, TV[i], 4'h1});
      reg_wr(1, 32'h3);
      wait_idle();
      chk("R2", "setup cycles", m_pre, int'(TV[i][15:12]) + int'(TV[i][11:8]) + 2);
      chk("R2", "active cycles", m_act, int'(TV[i][7:4]) + 1);
      chk("R2", "hold cycles", m_post, int'(TV[i][3:0]) + 1);
    end
    chk("R3", "data errors", data_err, 0);

    // R3 / R8 multi-word frame, interrupt disabled
    reg_wr(0, {12'h0, 16'h1111, 4'h1});
    src_n = 3; w0 = words;
    reg_wr(1, 32'h3);
    wait_idle();
    chk("R3", "words per frame", words - w0, 3);
    chk("R3", "data errors", data_err, 0);
    chk("R8", "busy after end", busy, 0);
    chk("R9", "done set", done, 1);
    chk("R9", "irq masked", irq, 0);
    src_n = 1;

    // R9 enable and clear
    reg_wr(3, 32'h2);
    chk("R9", "irq enabled", irq, 1);
    reg_wr(3, 32'h3);
    chk("R9", "done cleared", done, 0);
    chk("R9", "irq cleared", irq, 0);

    // R4 negatives
    w0 = words;
    reg_wr(1, 32'h2);
    repeat (10) @(negedge clk);
    chk("R4", "no start without mode", words - w0 + int'(busy), 0);
    reg_wr(0, {12'h0, 16'h0000, 4'h0});
    reg_wr(1, 32'h3);
    repeat (10) @(negedge clk);
    chk("R4", "no start when disabled", words - w0 + int'(busy), 0);
    reg_wr(0, {12'h0, 16'h0000, 4'h1});

    // R5 hardware trigger
    w0 = words;
    reg_wr(1, 32'h8000_0019);
    te_pulse(); wait_idle();
    chk("R5", "te frame", words - w0, 1);
    te_pulse(); wait_idle();
    chk("R6", "per-te second frame", words - w0, 2);
    reg_wr(1, 32'h8000_0009);
    te_pulse(); repeat (10) @(negedge clk);
    chk("R5", "masked te", words - w0 + int'(busy), 2);

    // R6 one start per arming
    w0 = words;
    reg_wr(1, 32'h19);
    repeat (5) @(negedge clk);
    chk("R6", "arm alone no start", words - w0 + int'(busy), 0);
    te_pulse(); wait_idle();
    chk("R6", "armed te frame", words - w0, 1);
    te_pulse(); repeat (10) @(negedge clk);
    chk("R6", "second te ignored", words - w0 + int'(busy), 1);
    reg_wr(1, 32'h19);
    te_pulse(); wait_idle();
    chk("R6", "rearmed frame", words - w0, 2);

    // R7 triggers during a busy frame
    reg_wr(0, {12'h0, 16'hFFFF, 4'h1});
    src_n = 3; w0 = words;
    reg_wr(1, 32'h8000_001B);
    repeat (5) @(negedge clk);
    chk("R7", "busy", busy, 1);
    reg_wr(1, 32'h8000_001B);
    te_pulse();
    wait_idle();
    repeat (30) @(negedge clk);
    chk("R7", "words only from one frame", words - w0, 3);
    chk("R7", "idle afterwards", busy, 0);
    reg_wr(1, 32'h0);
    src_n = 1;

    // R9 set and clear in the same cycle
    reg_wr(3, 32'h1);
    reg_wr(0, {12'h0, 16'h000F, 4'h1});
    chk("R9", "done clear before", done, 0);
    reg_wr(1, 32'h3);
    while (wr_n) @(negedge clk);
    while (!wr_n) @(negedge clk);
    repeat (14) @(negedge clk);
    reg_wr(3, 32'h1);
    chk("R9", "set wins over clear", done, 1);
    chk("R8", "busy after end", busy, 0);
    reg_wr(3, 32'h1);
    chk("R9", "later clear", done, 0);

    // R10 automatic refresh
    reg_wr(0, {12'h0, 16'h0000, 4'h1});
    w0 = words;
    reg_wr(2, 32'd20);
    repeat (300) @(negedge clk);
    chk("R10", "auto frames >= 5", int'((words - w0) >= 5), 1);
    chk("R10", "idle gap", last_idle, 20);
    reg_wr(2, 32'd0);
    wait_idle();
    w0 = words;
    repeat (200) @(negedge clk);
    chk("R10", "disabled no frames", words - w0, 0);
    chk("R10", "disabled idle", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule